// File: doc/BRIEF.md
# Voice Channel Run Controller

This block tracks whether each of 32 voice channels in one bank is running or stopped. Software starts channels through one register location. A 1 in bit n of the written word starts channel n. Software stops channels through a second location in the same way. A read from either location returns the same 32-bit running-status vector. Bit n of every vector belongs to channel n.

While a channel runs, the block watches three end conditions reported by that channel's address and envelope engines. The first is the sample offset reaching the end offset with looping off. The second is the envelope attenuation hitting its floor. The third is a delay-stop countdown that has expired. Any one of them stops the channel on its own. The block drives one-cycle start and stop strobes toward the engines, one bit per channel, and only when a channel actually changes state. A stopped channel adds nothing to the mix.

Each channel is a two-state machine, `CH_STOPPED` and `CH_RUNNING`, with these transitions:
- `GO`: `CH_STOPPED` to `CH_RUNNING`, on a start command with no halt request.
- `HALT`: `CH_RUNNING` to `CH_STOPPED`, on a stop command or an end condition.
- `HOLD`: all other cases, where the state stays as it is.

Top module: `voice_run_ctrl`

## Requirements
- R1: After reset every channel is stopped: `run_status`, `start_pulse` and `stop_pulse` are all 0.
- R2: A write to offset B4h with bit n = 1 sets channel n running at the next clock edge. Bits written as 0 leave their channels unchanged.
- R3: A write to offset B8h with bit n = 1 sets channel n stopped at the next clock edge. Bits written as 0 leave their channels unchanged.
- R4: `reg_rdata` equals `run_status` whenever `reg_addr` is B4h or B8h, and is 0 at any other address.
- R5: A running channel stops at the next edge when its `loop_en` bit is 0 and its unsigned `cur_ofs` field is greater than or equal to its `end_ofs` field. With `loop_en` = 1 the offsets have no effect.
- R6: A running channel stops at the next edge when its `env_floor` bit is 1.
- R7: A running channel stops at the next edge when both its `dly_stop_mode` bit and its `dly_done` bit are 1. Either bit alone has no effect.
- R8: When a start command meets an end condition on the same channel in the same cycle, the stop wins: the channel stays stopped and no start pulse is emitted.
- R9: A channel moves from stopped to running only through a start write. A start write to a running channel and a stop write to a stopped channel produce no pulse.
- R10: `start_pulse[n]` (or `stop_pulse[n]`) is 1 for exactly the one cycle in which `run_status[n]` has just risen (or fallen), and is 0 otherwise.
- R11: A write to any offset other than B4h and B8h changes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Register offset for the write or read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, one bit per channel |
| reg_rdata | output | 32 | Read data (running-status vector) |
| loop_en | input | 32 | Per-channel loop enable |
| cur_ofs | input | 640 | Current sample offsets, 20 bits per channel, channel n at [20n +: 20] |
| end_ofs | input | 640 | End sample offsets, same packing |
| env_floor | input | 32 | Per-channel envelope-at-floor flag |
| dly_stop_mode | input | 32 | Per-channel delay-stop mode flag |
| dly_done | input | 32 | Per-channel delay counter reached zero |
| run_status | output | 32 | Running (1) or stopped (0) per channel |
| start_pulse | output | 32 | One-cycle strobe when a channel starts |
| stop_pulse | output | 32 | One-cycle strobe when a channel stops |

## Verification
A write or end condition presented during a cycle is registered at the next rising edge. At that edge `run_status` and the matching pulse both change, and one edge later the pulse falls again. The bench drives inputs on falling edges and samples status and pulses 1 ns after the following rising edge. It then checks that the pulses are back to 0 after one more edge. `reg_rdata` is combinational, so the bench reads it between edges with the address held steady.

// File: rtl/voice_ctrl_pkg.sv
package voice_ctrl_pkg;
    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;
endpackage

// File: rtl/voice_end_detect.sv
module voice_end_detect #(
    parameter int OFS_W = 20
) (
    input  logic             loop_en,
    input  logic [OFS_W-1:0] cur_ofs,
    input  logic [OFS_W-1:0] end_ofs,
    input  logic             env_floor,
    input  logic             dly_stop_mode,
    input  logic             dly_done,
    output logic             end_hit
);
    logic out_of_data;
    logic dly_expired;

    always_comb begin
        out_of_data = !loop_en && (cur_ofs >= end_ofs);
        dly_expired = dly_stop_mode && dly_done;
        end_hit     = out_of_data || env_floor || dly_expired;
    end
endmodule

// File: rtl/voice_cmd_decode.sv
module voice_cmd_decode #(
    parameter int              NUM_CH    = 32,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] START_OFS = 8'hB4,
    parameter logic [ADDR_W-1:0] STOP_OFS  = 8'hB8
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NUM_CH-1:0] reg_wdata,
    input  logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] start_vec,
    output logic [NUM_CH-1:0] stop_vec,
    output logic [NUM_CH-1:0] reg_rdata
);
    logic hit_start;
    logic hit_stop;

    always_comb begin
        hit_start = (reg_addr == START_OFS);
        hit_stop  = (reg_addr == STOP_OFS);
        start_vec = (reg_wr && hit_start) ? reg_wdata : '0;
        stop_vec  = (reg_wr && hit_stop)  ? reg_wdata : '0;
        reg_rdata = (hit_start || hit_stop) ? status : '0;
    end
endmodule

// File: rtl/voice_chan_fsm.sv
module voice_chan_fsm
    import voice_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic end_hit,
    output logic running,
    output logic start_p,
    output logic stop_p
);
    ch_state_e state;
    ch_state_e state_nx;
    logic      halt_req;

    assign halt_req = stop_cmd || end_hit;

    // next-state logic: GO, HALT, HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_STOPPED: if (start_cmd && !halt_req) state_nx = CH_RUNNING;
            CH_RUNNING: if (halt_req)               state_nx = CH_STOPPED;
            default:                                state_nx = CH_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_STOPPED;
        else        state <= state_nx;
    end

    // output register: strobes mark a real transition only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= (state == CH_STOPPED) && (state_nx == CH_RUNNING);
            stop_p  <= (state == CH_RUNNING) && (state_nx == CH_STOPPED);
        end
    end

    assign running = (state == CH_RUNNING);
endmodule

// File: rtl/voice_run_ctrl.sv
module voice_run_ctrl #(
    parameter int                NUM_CH    = 32,
    parameter int                OFS_W     = 20,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] START_OFS = 8'hB4,
    parameter logic [ADDR_W-1:0] STOP_OFS  = 8'hB8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic [NUM_CH-1:0]       reg_wdata,
    output logic [NUM_CH-1:0]       reg_rdata,
    input  logic [NUM_CH-1:0]       loop_en,
    input  logic [NUM_CH*OFS_W-1:0] cur_ofs,
    input  logic [NUM_CH*OFS_W-1:0] end_ofs,
    input  logic [NUM_CH-1:0]       env_floor,
    input  logic [NUM_CH-1:0]       dly_stop_mode,
    input  logic [NUM_CH-1:0]       dly_done,
    output logic [NUM_CH-1:0]       run_status,
    output logic [NUM_CH-1:0]       start_pulse,
    output logic [NUM_CH-1:0]       stop_pulse
);
    logic [NUM_CH-1:0] start_vec;
    logic [NUM_CH-1:0] stop_vec;
    logic [NUM_CH-1:0] end_vec;

    voice_cmd_decode #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .START_OFS (START_OFS),
        .STOP_OFS  (STOP_OFS)
    ) u_decode (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .status    (run_status),
        .start_vec (start_vec),
        .stop_vec  (stop_vec),
        .reg_rdata (reg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        voice_end_detect #(
            .OFS_W (OFS_W)
        ) u_end (
            .loop_en       (loop_en[ch]),
            .cur_ofs       (cur_ofs[ch*OFS_W +: OFS_W]),
            .end_ofs       (end_ofs[ch*OFS_W +: OFS_W]),
            .env_floor     (env_floor[ch]),
            .dly_stop_mode (dly_stop_mode[ch]),
            .dly_done      (dly_done[ch]),
            .end_hit       (end_vec[ch])
        );

        voice_chan_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_cmd (start_vec[ch]),
            .stop_cmd  (stop_vec[ch]),
            .end_hit   (end_vec[ch]),
            .running   (run_status[ch]),
            .start_p   (start_pulse[ch]),
            .stop_p    (stop_pulse[ch])
        );
    end
endmodule

// File: rtl/voice_run_ctrl_chk.sv
module voice_run_ctrl_chk #(
    parameter int                NUM_CH    = 32,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] START_OFS = 8'hB4,
    parameter logic [ADDR_W-1:0] STOP_OFS  = 8'hB8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [NUM_CH-1:0] reg_wdata,
    input logic [NUM_CH-1:0] reg_rdata,
    input logic [NUM_CH-1:0] run_status,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] stop_pulse
);
    logic              wr_start;
    logic              wr_stop;
    logic [NUM_CH-1:0] start_bits;

    assign wr_start   = reg_wr && (reg_addr == START_OFS);
    assign wr_stop    = reg_wr && (reg_addr == STOP_OFS);
    assign start_bits = wr_start ? reg_wdata : '0;

    // R3: written stop bits are clear one edge later
    a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> ((run_status & $past(reg_wdata)) == '0));

    // R9: a rising status bit must have had a start bit written
    a_r9_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((run_status & ~$past(run_status) & ~$past(start_bits)) == '0));

    // R10: start strobe marks exactly the rising bits
    a_r10_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (start_pulse == (run_status & ~$past(run_status))));

    // R10: stop strobe marks exactly the falling bits
    a_r10_stop_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stop_pulse == (~run_status & $past(run_status))));

    // R4: both command locations read back the status vector
    a_r4_read_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == START_OFS) || (reg_addr == STOP_OFS)) |-> (reg_rdata == run_status));

    // R11: writes elsewhere leave the status untouched
    a_r11_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !wr_start && !wr_stop) |=> ((run_status & ~$past(run_status)) == '0));
endmodule

bind voice_run_ctrl voice_run_ctrl_chk #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .START_OFS (START_OFS),
    .STOP_OFS  (STOP_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .run_status  (run_status),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse)
);

// File: tb/test_voice_run_ctrl.sv
`timescale 1ns/1ps
module test_voice_run_ctrl;
    localparam int NUM_CH = 32;
    localparam int OFS_W  = 20;
    localparam logic [7:0] A_START = 8'hB4;
    localparam logic [7:0] A_STOP  = 8'hB8;
    localparam int N_VEC = 7;

    // entry: {addr, write data, expected status after the write}
    localparam logic [71:0] VECS [N_VEC] = '{
        {8'hB4, 32'hFFFF_0000, 32'hFFFF_0000},
        {8'hB8, 32'h0F0F_0F0F, 32'hF0F0_0000},
        {8'hB4, 32'h0000_000F, 32'hF0F0_000F},
        {8'h10, 32'hFFFF_FFFF, 32'hF0F0_000F},
        {8'hB8, 32'h8000_0001, 32'h70F0_000E},
        {8'hB4, 32'h0000_0000, 32'h70F0_000E},
        {8'hB8, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [7:0]              reg_addr = '0;
    logic                    reg_wr = 1'b0;
    logic [NUM_CH-1:0]       reg_wdata = '0;
    logic [NUM_CH-1:0]       reg_rdata;
    logic [NUM_CH-1:0]       loop_en = '1;
    logic [NUM_CH*OFS_W-1:0] cur_ofs = '0;
    logic [NUM_CH*OFS_W-1:0] end_ofs = '0;
    logic [NUM_CH-1:0]       env_floor = '0;
    logic [NUM_CH-1:0]       dly_stop_mode = '0;
    logic [NUM_CH-1:0]       dly_done = '0;
    logic [NUM_CH-1:0]       run_status;
    logic [NUM_CH-1:0]       start_pulse;
    logic [NUM_CH-1:0]       stop_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    voice_run_ctrl i_voice_run_ctrl (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .loop_en (loop_en), .cur_ofs (cur_ofs), .end_ofs (end_ofs),
        .env_floor (env_floor), .dly_stop_mode (dly_stop_mode), .dly_done (dly_done),
        .run_status (run_status), .start_pulse (start_pulse), .stop_pulse (stop_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one write, sample 1 ns after the edge that registers it
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic end_write();
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic one_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        for (int c = 0; c < NUM_CH; c++) end_ofs[c*OFS_W +: OFS_W] = 20'd100;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 status", run_status, '0);
        chk("R1 start_pulse", start_pulse, '0);
        chk("R1 stop_pulse", stop_pulse, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R2, R3, R11, R10
        prev = '0;
        for (int i = 0; i < N_VEC; i++) begin
            logic [31:0] expd;
            expd = VECS[i][31:0];
            do_write(VECS[i][71:64], VECS[i][63:32]);
            chk("R2/R3/R11 status", run_status, expd);
            chk("R10 start_pulse", start_pulse, expd & ~prev);
            chk("R10 stop_pulse", stop_pulse, prev & ~expd);
            end_write();
            one_edge();
            chk("R10 pulses drop", start_pulse | stop_pulse, '0);
            prev = expd;
        end

        // R4: readback at both locations and elsewhere
        do_write(A_START, 32'h0000_00A5);
        end_write();
        reg_addr = A_START;
        #1 chk("R4 read start loc", reg_rdata, 32'h0000_00A5);
        reg_addr = A_STOP;
        #1 chk("R4 read stop loc", reg_rdata, 32'h0000_00A5);
        reg_addr = 8'h44;
        #1 chk("R4 read other", reg_rdata, '0);

        // R9: restart running channel 0, stop stopped channel 8
        do_write(A_START, 32'h0000_0001);
        chk("R9 start on running no pulse", start_pulse, '0);
        end_write();
        do_write(A_STOP, 32'h0000_0100);
        chk("R9 stop on stopped no pulse", stop_pulse, '0);
        chk("R9 status kept", run_status, 32'h0000_00A5);
        end_write();

        // R5: offsets on channel 2 (running); looping first
        @(negedge clk);
        cur_ofs[2*OFS_W +: OFS_W] = 20'd100;
        one_edge();
        chk("R5 loop on keeps running", run_status, 32'h0000_00A5);
        @(negedge clk);
        cur_ofs[2*OFS_W +: OFS_W] = 20'd99;
        loop_en[2] = 1'b0;
        one_edge();
        chk("R5 below end keeps running", run_status, 32'h0000_00A5);
        @(negedge clk);
        cur_ofs[2*OFS_W +: OFS_W] = 20'd100;
        one_edge();
        chk("R5 offset reached stops", run_status, 32'h0000_00A1);
        chk("R5 stop pulse", stop_pulse, 32'h0000_0004);
        @(negedge clk);
        loop_en[2] = 1'b1;
        cur_ofs[2*OFS_W +: OFS_W] = 20'd0;

        // R6: envelope floor on channel 5
        env_floor[5] = 1'b1;
        one_edge();
        chk("R6 floor stops", run_status, 32'h0000_0081);
        @(negedge clk);
        // R8: start channel 5 while its floor flag is still set
        reg_addr = A_START; reg_wdata = 32'h0000_0020; reg_wr = 1'b1;
        one_edge();
        chk("R8 stop wins status", run_status, 32'h0000_0081);
        chk("R8 stop wins no pulse", start_pulse, '0);
        end_write();
        env_floor[5] = 1'b0;

        // R7: delay-stop on channel 7
        dly_stop_mode[7] = 1'b1;
        one_edge();
        chk("R7 mode alone keeps running", run_status, 32'h0000_0081);
        @(negedge clk);
        dly_stop_mode[7] = 1'b0;
        dly_done[7] = 1'b1;
        one_edge();
        chk("R7 done alone keeps running", run_status, 32'h0000_0081);
        @(negedge clk);
        dly_stop_mode[7] = 1'b1;
        one_edge();
        chk("R7 both stop", run_status, 32'h0000_0001);
        @(negedge clk);
        dly_stop_mode[7] = 1'b0;
        dly_done[7] = 1'b0;

        // R1: reset mid-run
        rst_n = 1'b0;
        #1 chk("R1 reset clears", run_status, '0);
        @(negedge clk);
        rst_n = 1'b1;
        one_edge();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule